// File: doc/BRIEF.md
# T1 Framing Performance Monitor

This block gathers framing-quality statistics for a T1 receive framer running either D4 (12-frame) or ESF (24-frame) superframes. A T1 frame is 193 bits: twenty-four 8-bit channels plus one overhead framing bit. The framer supplies a frame strobe once per 125 µs frame and single-cycle event pulses. These pulses mark a terminal-framing (Ft) bit error, a signalling-framing (Fs) bit error, a CRC-6 mismatch for an ESF superframe, a loss of frame sync and a shift of the frame alignment position. The framer also supplies a level that is high while basic frame sync is held.

Five live counters accumulate these events: framing bit errors, CRC-6 errors, out-of-frame events, change-of-alignment events, and superframe periods spent without basic sync. A one-second tick copies every live count into a snapshot register in one cycle and restarts the live counts. Each event class also sets a sticky status bit. A mask selects which status bits drive the interrupt output. A small synchronous register port reads all counters and snapshots, and writes the status and mask.

Top module: `t1_frm_perfmon`

## Requirements
- R1: After reset, every live counter and every snapshot reads 0, the status register reads 0, the mask register reads 0x1F and irq is low.
- R2: In D4 mode (mode_esf=0) the framing bit error counter adds one for each of ft_err and fs_err, so both in one cycle add 2. In ESF mode (mode_esf=1) it counts ft_err only and ignores fs_err.
- R3: The CRC-6 error counter adds one for each crc_err pulse in ESF mode. In D4 mode crc_err leaves that counter unchanged.
- R4: The out-of-frame counter adds one per sync_loss pulse. The change-of-alignment counter adds one per align_shift pulse.
- R5: While sync_ok is low, the superframe-loss counter adds one on every 12th frame_stb in D4 mode and on every 24th in ESF mode. While sync_ok is high the frame phase is held at zero, so the first increment after a loss comes a full superframe after it.
- R6: On a sec_tick cycle, all five snapshots load the live values from before that cycle and the live counters restart. An event in the tick cycle is counted in the new interval.
- R7: Live counters are 8 bits wide and stay at 255 instead of wrapping.
- R8: Status bits are sticky. Bit 0 is a framing bit error, bit 1 a CRC-6 error, bit 2 out-of-frame, bit 3 change of alignment and bit 4 a superframe-loss increment. Writing 1 to a bit at address 0xD clears it. An event arriving in the same cycle as the clear wins.
- R9: The mask at address 0xE resets to all ones. irq goes high, one cycle after the status and mask registers change, whenever any status bit has its mask bit at 0.
- R10: reg_rdata shows, one cycle after reg_addr is applied, the live counters at addresses 0 to 4 (framing bit, CRC-6, out-of-frame, change of alignment, superframe loss), the matching snapshots at 8 to 12, status at 0xD and mask at 0xE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle strobe per received frame |
| mode_esf | input | 1 | 1 selects ESF (24 frames), 0 selects D4 (12 frames) |
| sync_ok | input | 1 | High while basic frame sync is held |
| ft_err | input | 1 | Terminal-framing bit error pulse |
| fs_err | input | 1 | Signalling-framing bit error pulse |
| crc_err | input | 1 | CRC-6 mismatch pulse for a superframe |
| sync_loss | input | 1 | Pulse on each loss of frame sync |
| align_shift | input | 1 | Pulse on each shift of the frame alignment |
| sec_tick | input | 1 | One-second snapshot tick |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench goes after four corner cases. First, Ft and Fs errors in the same cycle in both modes: a design that ORs them would give 1 in D4, and one that ignores the mode would count Fs errors in ESF. Second, the superframe-loss phase after a short loss, a resync and a new loss: a tracker that keeps its phase would step early. Third, an error in the same cycle as the second tick, which a design that drops or mis-assigns that event would lose or move into the snapshot. Fourth, saturation past 255 and a status clear that collides with a new event: a wrapping counter would read a small value, and a clear-wins status register would lose the event.

// File: rtl/t1pm_pkg.sv
package t1pm_pkg;
  localparam int AW     = 4;
  localparam int NCTR   = 5;
  localparam int SW     = 5;
  localparam int IW     = 2;

  localparam int IX_FBE   = 0;
  localparam int IX_CRC   = 1;
  localparam int IX_OOF   = 2;
  localparam int IX_COFA  = 3;
  localparam int IX_MFOOF = 4;

  localparam logic [AW-1:0] A_SNAP = 4'h8;
  localparam logic [AW-1:0] A_STS  = 4'hD;
  localparam logic [AW-1:0] A_MSK  = 4'hE;
endpackage

// File: rtl/t1pm_cnt.sv
module t1pm_cnt #(
  parameter int W  = 8,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [IW-1:0] inc,
  output logic [W-1:0]  live,
  output logic [W-1:0]  snap
);
  localparam logic [W:0] MAXV = {1'b0, {W{1'b1}}};

  logic [W:0] base;
  logic [W:0] sum;

  always_comb begin
    base = tick ? '0 : {1'b0, live};
    sum  = base + {{(W+1-IW){1'b0}}, inc};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
      snap <= '0;
    end else begin
      if (tick) snap <= live;
      live <= (sum > MAXV) ? MAXV[W-1:0] : sum[W-1:0];
    end
  end
endmodule

// File: rtl/t1pm_sfper.sv
module t1pm_sfper #(
  parameter int D4_LEN  = 12,
  parameter int ESF_LEN = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_stb,
  input  logic mode_esf,
  input  logic sync_ok,
  output logic sf_pulse
);
  localparam int FW = $clog2(ESF_LEN + 1);
  localparam logic [FW-1:0] D4_LAST  = FW'(D4_LEN - 1);
  localparam logic [FW-1:0] ESF_LAST = FW'(ESF_LEN - 1);

  logic [FW-1:0] phase;
  logic          at_end;

  assign at_end = (phase >= (mode_esf ? ESF_LAST : D4_LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      sf_pulse <= 1'b0;
    end else begin
      sf_pulse <= 1'b0;
      if (sync_ok) begin
        phase <= '0;
      end else if (frame_stb) begin
        if (at_end) begin
          phase    <= '0;
          sf_pulse <= 1'b1;
        end else begin
          phase <= phase + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/t1pm_irq.sv
module t1pm_irq #(
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] set,
  input  logic          sts_we,
  input  logic          msk_we,
  input  logic [SW-1:0] wdata,
  output logic [SW-1:0] sts,
  output logic [SW-1:0] msk,
  output logic          irq
);
  logic [SW-1:0] clr;

  assign clr = sts_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts <= '0;
      msk <= '1;
      irq <= 1'b0;
    end else begin
      sts <= (sts & ~clr) | set;
      if (msk_we) msk <= wdata;
      irq <= |(sts & ~msk);
    end
  end
endmodule

// File: rtl/t1_frm_perfmon.sv
module t1_frm_perfmon
  import t1pm_pkg::*;
#(
  parameter int CW      = 8,
  parameter int D4_LEN  = 12,
  parameter int ESF_LEN = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_stb,
  input  logic          mode_esf,
  input  logic          sync_ok,
  input  logic          ft_err,
  input  logic          fs_err,
  input  logic          crc_err,
  input  logic          sync_loss,
  input  logic          align_shift,
  input  logic          sec_tick,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  output logic          irq
);
  logic [NCTR-1:0][IW-1:0] inc_v;
  logic [NCTR-1:0][CW-1:0] live_v;
  logic [NCTR-1:0][CW-1:0] snap_v;
  logic [SW-1:0]           set_v;
  logic [SW-1:0]           sts;
  logic [SW-1:0]           msk;
  logic                    sf_pulse;
  logic                    fs_counted;
  logic                    crc_counted;
  logic [CW-1:0]           rd_n;

  assign fs_counted  = fs_err & ~mode_esf;
  assign crc_counted = crc_err & mode_esf;

  always_comb begin
    inc_v           = '0;
    inc_v[IX_FBE]   = {1'b0, ft_err} + {1'b0, fs_counted};
    inc_v[IX_CRC]   = {1'b0, crc_counted};
    inc_v[IX_OOF]   = {1'b0, sync_loss};
    inc_v[IX_COFA]  = {1'b0, align_shift};
    inc_v[IX_MFOOF] = {1'b0, sf_pulse};
  end

  always_comb begin
    set_v           = '0;
    set_v[IX_FBE]   = ft_err | fs_counted;
    set_v[IX_CRC]   = crc_counted;
    set_v[IX_OOF]   = sync_loss;
    set_v[IX_COFA]  = align_shift;
    set_v[IX_MFOOF] = sf_pulse;
  end

  t1pm_sfper #(.D4_LEN(D4_LEN), .ESF_LEN(ESF_LEN)) u_sfper (
    .clk      (clk),
    .rst      (rst),
    .frame_stb(frame_stb),
    .mode_esf (mode_esf),
    .sync_ok  (sync_ok),
    .sf_pulse (sf_pulse)
  );

  for (genvar g = 0; g < NCTR; g++) begin : g_ctr
    t1pm_cnt #(.W(CW), .IW(IW)) u_cnt (
      .clk (clk),
      .rst (rst),
      .tick(sec_tick),
      .inc (inc_v[g]),
      .live(live_v[g]),
      .snap(snap_v[g])
    );
  end

  t1pm_irq #(.SW(SW)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .set   (set_v),
    .sts_we(reg_wr && (reg_addr == A_STS)),
    .msk_we(reg_wr && (reg_addr == A_MSK)),
    .wdata (reg_wdata[SW-1:0]),
    .sts   (sts),
    .msk   (msk),
    .irq   (irq)
  );

  always_comb begin
    rd_n = '0;
    for (int i = 0; i < NCTR; i++) begin
      if (reg_addr == AW'(i))          rd_n = live_v[i];
      if (reg_addr == A_SNAP + AW'(i)) rd_n = snap_v[i];
    end
    if (reg_addr == A_STS) rd_n = {{(CW-SW){1'b0}}, sts};
    if (reg_addr == A_MSK) rd_n = {{(CW-SW){1'b0}}, msk};
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_n;
  end
endmodule

// File: rtl/t1pm_chk.sv
module t1pm_chk
  import t1pm_pkg::*;
#(
  parameter int CW = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    tick,
  input logic                    mode_esf,
  input logic                    sync_ok,
  input logic                    sync_loss,
  input logic                    reg_wr,
  input logic [AW-1:0]           reg_addr,
  input logic [NCTR-1:0][CW-1:0] live_v,
  input logic [NCTR-1:0][CW-1:0] snap_v,
  input logic [SW-1:0]           sts,
  input logic [SW-1:0]           msk
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d === 1'b1 && rst === 1'b0)
      a_mask_reset_r9: assert (msk == '1);
  end

  p_crc_d4_r3: assert property (@(posedge clk) disable iff (rst)
    (!mode_esf && !tick) |=> $stable(live_v[IX_CRC]));

  p_oof_step_r4: assert property (@(posedge clk) disable iff (rst)
    (sync_loss && !tick && live_v[IX_OOF] != '1) |=>
      (live_v[IX_OOF] == $past(live_v[IX_OOF]) + CW'(1)));

  p_mfoof_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (sync_ok && $past(sync_ok) && !tick) |=> $stable(live_v[IX_MFOOF]));

  p_snapshot_r6: assert property (@(posedge clk) disable iff (rst)
    tick |=> (snap_v == $past(live_v)));

  for (genvar g = 0; g < NCTR; g++) begin : g_sat
    p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
      (live_v[g] == '1 && !tick) |=> (live_v[g] == '1));
  end

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == A_STS) |=> ((sts & $past(sts)) == $past(sts)));
endmodule

bind t1_frm_perfmon t1pm_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (sec_tick),
  .mode_esf (mode_esf),
  .sync_ok  (sync_ok),
  .sync_loss(sync_loss),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .live_v   (live_v),
  .snap_v   (snap_v),
  .sts      (sts),
  .msk      (msk)
);

// File: tb/tb_t1_frm_perfmon.sv
`timescale 1ns/1ps
module tb_t1_frm_perfmon;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_stb = 0, mode_esf = 0, sync_ok = 1;
  logic       ft_err = 0, fs_err = 0, crc_err = 0, sync_loss = 0, align_shift = 0;
  logic       sec_tick = 0, reg_wr = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       irq;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  t1_frm_perfmon dut (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .mode_esf(mode_esf),
    .sync_ok(sync_ok), .ft_err(ft_err), .fs_err(fs_err), .crc_err(crc_err),
    .sync_loss(sync_loss), .align_shift(align_shift), .sec_tick(sec_tick),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // vector: [10]esf [9]ft [8]fs [7]crc [6]loss [5]shift [4:3]fbe [2]crc [1]oof [0]cofa
  localparam logic [10:0] VEC [8] = '{
    11'b0_1_0_0_0_0_01_0_0_0,
    11'b0_0_1_0_0_0_01_0_0_0,
    11'b0_1_1_0_0_0_10_0_0_0,
    11'b1_0_1_0_0_0_00_0_0_0,
    11'b1_1_1_0_0_0_01_0_0_0,
    11'b1_0_0_1_0_0_00_1_0_0,
    11'b0_0_0_1_0_0_00_0_0_0,
    11'b1_0_0_0_1_1_00_0_1_1
  };

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    cyc();
    d = reg_rdata;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    cyc();
    reg_wr = 0;
  endtask

  task automatic tick();
    sec_tick = 1; cyc(); sec_tick = 0;
  endtask

  task automatic strobe(int n);
    for (int k = 0; k < n; k++) begin
      frame_stb = 1; cyc(); frame_stb = 0; cyc();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    cyc(3);
    rst = 0;
    cyc();
    // R1 reset state (read through R10 map)
    for (int a = 0; a < 5; a++) begin
      rd(4'(a), d);     chk("R1 live", d, 8'h00);
      rd(4'(a + 8), d); chk("R1 snap", d, 8'h00);
    end
    rd(4'hD, d); chk("R1 status", d, 8'h00);
    rd(4'hE, d); chk("R1 mask", d, 8'h1F);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // vector table: R2 R3 R4 R10
    for (int v = 0; v < 8; v++) begin
      tick();
      mode_esf = VEC[v][10];
      ft_err = VEC[v][9]; fs_err = VEC[v][8]; crc_err = VEC[v][7];
      sync_loss = VEC[v][6]; align_shift = VEC[v][5];
      cyc();
      ft_err = 0; fs_err = 0; crc_err = 0; sync_loss = 0; align_shift = 0;
      rd(4'h0, d); chk("R2 framing bit count", d, {6'd0, VEC[v][4:3]});
      rd(4'h1, d); chk("R3 crc count", d, {7'd0, VEC[v][2]});
      rd(4'h2, d); chk("R4 oof count", d, {7'd0, VEC[v][1]});
      rd(4'h3, d); chk("R4 cofa count", d, {7'd0, VEC[v][0]});
    end

    // R6 tick with same-cycle event
    mode_esf = 0;
    tick();
    for (int k = 0; k < 3; k++) begin
      ft_err = 1; cyc(); ft_err = 0; cyc();
    end
    sec_tick = 1; ft_err = 1; cyc(); sec_tick = 0; ft_err = 0;
    rd(4'h8, d); chk("R6 snapshot", d, 8'd3);
    rd(4'h0, d); chk("R6 new interval", d, 8'd1);
    rd(4'h9, d); chk("R6 crc snapshot", d, 8'd0);

    // R5 D4 superframe-loss with phase restart
    tick();
    sync_ok = 0; strobe(5);
    sync_ok = 1; strobe(3);
    sync_ok = 0; strobe(11); cyc(2);
    rd(4'h4, d); chk("R5 D4 before 12th", d, 8'd0);
    strobe(1); cyc(2);
    rd(4'h4, d); chk("R5 D4 at 12th", d, 8'd1);
    rd(4'hD, d); chk("R8 mfoof status bit4", d & 8'h10, 8'h10);
    // R5 ESF
    sync_ok = 1; cyc(); mode_esf = 1; tick();
    sync_ok = 0; strobe(23); cyc(2);
    rd(4'h4, d); chk("R5 ESF before 24th", d, 8'd0);
    strobe(1); cyc(2);
    rd(4'h4, d); chk("R5 ESF at 24th", d, 8'd1);
    sync_ok = 1; cyc(2);

    // R7 saturation
    mode_esf = 0; tick();
    ft_err = 1; cyc(300); ft_err = 0;
    rd(4'h0, d); chk("R7 saturate", d, 8'd255);
    tick();
    rd(4'h8, d); chk("R7 snapshot of saturated", d, 8'd255);
    rd(4'h0, d); chk("R7 cleared after tick", d, 8'd0);

    // R8 / R9 status and interrupt
    wr(4'hD, 8'h1F);
    rd(4'hD, d); chk("R8 clear all", d, 8'h00);
    ft_err = 1; cyc(); ft_err = 0; cyc();
    rd(4'hD, d); chk("R8 sticky set", d, 8'h01);
    chk("R9 masked irq", {7'd0, irq}, 8'h00);
    wr(4'hE, 8'h1E); cyc();
    chk("R9 unmasked irq", {7'd0, irq}, 8'h01);
    reg_addr = 4'hD; reg_wdata = 8'h01; reg_wr = 1; ft_err = 1;
    cyc(); reg_wr = 0; ft_err = 0;
    rd(4'hD, d); chk("R8 set wins over clear", d, 8'h01);
    wr(4'hD, 8'h01); cyc();
    rd(4'hD, d); chk("R8 w1c", d, 8'h00);
    chk("R9 irq drops", {7'd0, irq}, 8'h00);
    wr(4'hE, 8'h1F);
    rd(4'hE, d); chk("R9 mask readback", d, 8'h1F);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule